// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Window

This block is a supervisory timer. Software must keep refreshing it. A prescaler divides the system clock into coarse ticks. The default divide ratio gives 0.6 s per tick at 50 MHz. On each tick a 10-bit down-counter steps by one. When the counter has reached zero, the next tick reloads it from the programmed initial value and raises a timeout flag. If the counter expires a second time while that flag is still set, the block pulses its reset output for one clock. It does so only when the external no-reboot gate is open.

Software talks to the block through a 32-byte, byte-addressed window. Every access is a full 16-bit word at an even offset. Through the window, software can:
- write any data to the reload offset to restart the count, and read back the live count there;
- program the initial value, whose upper bits are spare storage;
- stop or run the counter with a halt bit;
- clear the sticky flags by writing ones to them.

Reads come straight from a multiplexer, with no wait state. Writes take effect at the next clock edge.

Top module: `wdog_timer`

## Requirements
- R1: While the halt bit is 0, the count drops by one every TICK_DIV clocks. The first drop comes TICK_DIV clocks after the write that clears halt or after a reload write. While halted, the prescaler holds at zero.
- R2: A write of any data to offset 0x00 loads the count from the stored initial value at the next edge. A read of 0x00 returns the count in bits [9:0] and zeros above.
- R3: A reload write on the same clock as a tick wins: the count takes the initial value, not a decremented one, and no expiry is recorded.
- R4: Offset 0x12 holds the initial value in bits [9:0]. It holds free storage in bits [15:10], which every write to 0x12 updates and reads return.
- R5: A write to 0x12 whose bits [9:0] are 0, 1, 2 or 3 leaves the stored initial value unchanged.
- R6: Offset 0x08 bit 11 is the halt bit. It reads back as written, and all other bits of 0x08 read 0. While it is 1, the count does not change except by reload.
- R7: A tick that finds the count at 0 reloads the initial value and sets bit 0 of offset 0x04 (the timeout flag).
- R8: A tick that finds the count at 0 while the timeout flag is already set is a second expiry.
  - If sys_ctrl bit 5 (no-reboot) is 0, wdt_rst is high for exactly one clock and bit 0 of offset 0x06 is set.
  - If sys_ctrl bit 5 is 1, wdt_rst stays low and bit 1 of offset 0x06 is set.
- R9: The status bits are write-one-to-clear. Writing 1 to bit 0 of 0x04 clears it, writing 0x0003 to 0x06 clears both of its bits, and writing 0 bits leaves them set. A set event on the same clock as a clear wins.
- R10: After reset, the count is 4, the initial value is 4 with spare bits 0, halt is 1, all status bits are 0 and wdt_rst is 0.
- R11: Reads of offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one 16-bit word |
| addr | input | 5 | Byte offset inside the window |
| wr_data | input | 16 | Write data |
| sys_ctrl | input | SYS_W | External control word; bit 5 is the no-reboot gate |
| rd_data | output | 16 | Read data for `addr`, combinational |
| wdt_rst | output | 1 | One-clock reset request on second expiry |

## Verification
The bench aims a reload write at the exact clock of a tick. A design that let the decrement win would read one below the initial value.

It writes initial values below 4 with non-zero spare bits. This catches two faults: a design that accepts the small value, and a design that rejects the whole word and loses the spare bits.

It drives the counter through two expiries, once with no-reboot set and once with it clear. This exposes a reset that ignores the gate, a reset that lasts more than one clock, or a flag set in the wrong status register.

Status clearing is checked with zero bits and with one bits. Unmapped offsets are written and read back, which catches a decoder that aliases them onto real registers.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT_A = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT_B = 5'h06;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_INIT   = 5'h12;

    localparam int HALT_BIT     = 11;
    localparam int NOREBOOT_BIT = 5;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int TICK_DIV = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q == LAST);
        div_d = div_q + PW'(1);
        if (!run || restart || tick) begin
            div_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        init_val,
    input  logic [DATA_W-CNT_W-1:0] init_hi,
    input  logic                    halt,
    input  logic                    sts_timeout,
    input  logic                    sts_rst,
    input  logic                    sts_blocked,
    output logic [DATA_W-1:0]       rd_data
);
    always_comb begin
        rd_data = '0;
        case (addr)
            OFF_RELOAD: rd_data[CNT_W-1:0] = cnt;
            OFF_STAT_A: rd_data[0] = sts_timeout;
            OFF_STAT_B: rd_data[1:0] = {sts_blocked, sts_rst};
            OFF_CTRL:   rd_data[HALT_BIT] = halt;
            OFF_INIT:   rd_data = {init_hi, init_val};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 30_000_000,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4,
    parameter int SYS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SYS_W-1:0]  sys_ctrl,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst
);
    localparam int HI_W = DATA_W - CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] init_val;
        logic [HI_W-1:0]  init_hi;
        logic             halt;
        logic             sts_timeout;
        logic             sts_rst;
        logic             sts_blocked;
        logic             rst_pulse;
    } wdog_state_t;

    wdog_state_t st_d, st_q;
    logic tick, wr_reload, no_reboot;
    logic set_to, set_rst, set_blk, clr_to, clr_rst, clr_blk;
    logic unused_sys;

    assign wr_reload  = wr_en && (addr == OFF_RELOAD);
    assign no_reboot  = sys_ctrl[NOREBOOT_BIT];
    assign unused_sys = ^sys_ctrl;

    wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!st_q.halt),
        .restart (wr_reload),
        .tick    (tick)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        set_to  = 1'b0;
        set_rst = 1'b0;
        set_blk = 1'b0;
        clr_to  = 1'b0;
        clr_rst = 1'b0;
        clr_blk = 1'b0;

        if (wr_reload) begin
            st_d.cnt = st_q.init_val;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.init_val;
                if (st_q.sts_timeout) begin
                    if (!no_reboot) begin
                        st_d.rst_pulse = 1'b1;
                        set_rst        = 1'b1;
                    end else begin
                        set_blk = 1'b1;
                    end
                end else begin
                    set_to = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (wr_en) begin
            case (addr)
                OFF_INIT: begin
                    st_d.init_hi = wr_data[DATA_W-1:CNT_W];
                    if (wr_data[CNT_W-1:0] >= CNT_W'(INIT_MIN)) begin
                        st_d.init_val = wr_data[CNT_W-1:0];
                    end
                end
                OFF_CTRL:   st_d.halt = wr_data[HALT_BIT];
                OFF_STAT_A: clr_to = wr_data[0];
                OFF_STAT_B: begin
                    clr_rst = wr_data[0];
                    clr_blk = wr_data[1];
                end
                default: ;
            endcase
        end

        st_d.sts_timeout = (st_q.sts_timeout && !clr_to)  || set_to;
        st_d.sts_rst     = (st_q.sts_rst     && !clr_rst) || set_rst;
        st_d.sts_blocked = (st_q.sts_blocked && !clr_blk) || set_blk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt         <= CNT_W'(INIT_RST);
            st_q.init_val    <= CNT_W'(INIT_RST);
            st_q.init_hi     <= '0;
            st_q.halt        <= 1'b1;
            st_q.sts_timeout <= 1'b0;
            st_q.sts_rst     <= 1'b0;
            st_q.sts_blocked <= 1'b0;
            st_q.rst_pulse   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    wdog_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .addr        (addr),
        .cnt         (st_q.cnt),
        .init_val    (st_q.init_val),
        .init_hi     (st_q.init_hi),
        .halt        (st_q.halt),
        .sts_timeout (st_q.sts_timeout),
        .sts_rst     (st_q.sts_rst),
        .sts_blocked (st_q.sts_blocked),
        .rd_data     (rd_data)
    );

    assign wdt_rst = st_q.rst_pulse;

    logic [CNT_W-1:0] mon_cnt, mon_init;
    logic             mon_halt, mon_to;
    assign mon_cnt  = st_q.cnt;
    assign mon_init = st_q.init_val;
    assign mon_halt = st_q.halt;
    assign mon_to   = st_q.sts_timeout;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int SYS_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [SYS_W-1:0]  sys_ctrl,
    input logic [DATA_W-1:0] rd_data,
    input logic              wdt_rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  init_val,
    input logic              halt,
    input logic              sts_to
);
    logic mapped;
    assign mapped = (addr == OFF_RELOAD) || (addr == OFF_STAT_A) ||
                    (addr == OFF_STAT_B) || (addr == OFF_CTRL) || (addr == OFF_INIT);

    a_r8_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    a_r8_noreboot_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> !$past(sys_ctrl[NOREBOOT_BIT]));

    a_r8_rst_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> sts_to);

    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt) && !$past(wr_en && addr == OFF_RELOAD)) |-> (cnt == $past(cnt)));

    a_r2_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && addr == OFF_RELOAD) |-> (cnt == $past(init_val)));

    a_r5_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(INIT_MIN));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rd_data == '0));
endmodule

bind wdog_timer wdog_timer_chk #(
    .CNT_W    (CNT_W),
    .INIT_MIN (INIT_MIN),
    .SYS_W    (SYS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .sys_ctrl (sys_ctrl),
    .rd_data  (rd_data),
    .wdt_rst  (wdt_rst),
    .cnt      (mon_cnt),
    .init_val (mon_init),
    .halt     (mon_halt),
    .sts_to   (mon_to)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  sys_ctrl = 8'h20;
    logic [15:0] rd_data;
    logic        wdt_rst;

    int errors = 0;
    int checks = 0;
    int rst_pulses = 0;
    logic [15:0] v;

    always #10 clk = ~clk;

    wdog_timer #(.TICK_DIV(4)) u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .sys_ctrl(sys_ctrl), .rd_data(rd_data), .wdt_rst(wdt_rst)
    );

    always @(negedge clk) if (rst_n && wdt_rst) rst_pulses++;

    // {write data, expected read of 0x12}
    localparam logic [31:0] VEC [7] = '{
        {16'h0005, 16'h0005},
        {16'h0003, 16'h0005},
        {16'hFC10, 16'hFC10},
        {16'h0401, 16'h0410},
        {16'h03FF, 16'h03FF},
        {16'h0000, 16'h03FF},
        {16'h8004, 16'h8004}
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(5'h00, v); check("R10 count", v, 16'h0004);
        rd(5'h04, v); check("R10 stat_a", v, 16'h0000);
        rd(5'h06, v); check("R10 stat_b", v, 16'h0000);
        rd(5'h08, v); check("R10 ctrl", v, 16'h0800);
        rd(5'h12, v); check("R10 init", v, 16'h0004);
        check("R10 wdt_rst", {15'b0, wdt_rst}, 16'h0000);

        // R6 halted after reset: count frozen
        cyc(40);
        rd(5'h00, v); check("R6 halted count", v, 16'h0004);

        // R4 / R5 vector table
        for (int i = 0; i < 7; i++) begin
            wr(5'h12, VEC[i][31:16]);
            rd(5'h12, v);
            check((VEC[i][15:0] == 16'h0005 && i == 1) ? "R5 small rejected" : "R4 init field", v, VEC[i][15:0]);
        end
        wr(5'h12, 16'h0006);

        // R11 unmapped offsets
        wr(5'h0A, 16'hFFFF);
        wr(5'h02, 16'hFFFF);
        rd(5'h0A, v); check("R11 read 0x0A", v, 16'h0000);
        rd(5'h02, v); check("R11 read 0x02", v, 16'h0000);
        rd(5'h08, v); check("R11 ctrl untouched", v, 16'h0800);
        rd(5'h12, v); check("R11 init untouched", v, 16'h0006);
        rd(5'h00, v); check("R11 count untouched", v, 16'h0004);

        // R2 reload
        wr(5'h00, 16'h1234);
        rd(5'h00, v); check("R2 reload", v, 16'h0006);

        // R3 reload on tick clock, then R1 cadence
        wr(5'h08, 16'h0000);
        cyc(3);
        wr(5'h00, 16'h0000);
        rd(5'h00, v); check("R3 reload beats tick", v, 16'h0006);
        rd(5'h08, v); check("R6 halt cleared", v, 16'h0000);
        cyc(3);
        rd(5'h00, v); check("R1 before tick", v, 16'h0006);
        cyc(1);
        rd(5'h00, v); check("R1 first tick", v, 16'h0005);
        cyc(4);
        rd(5'h00, v); check("R1 second tick", v, 16'h0004);

        // R7 first expiry
        cyc(19);
        rd(5'h00, v); check("R7 count at zero", v, 16'h0000);
        rd(5'h04, v); check("R7 flag not yet", v, 16'h0000);
        cyc(1);
        rd(5'h04, v); check("R7 timeout flag", v, 16'h0001);
        rd(5'h00, v); check("R7 reloaded", v, 16'h0006);

        // R8 second expiry with no-reboot set
        cyc(28);
        rd(5'h06, v); check("R8 blocked flag", v, 16'h0002);
        check("R8 no reset when gated", 16'(rst_pulses), 16'h0000);

        // R9 write-one-to-clear
        wr(5'h04, 16'h0000);
        rd(5'h04, v); check("R9 zero write keeps", v, 16'h0001);
        wr(5'h06, 16'h0003);
        rd(5'h06, v); check("R9 clear stat_b", v, 16'h0000);
        wr(5'h04, 16'h0001);
        rd(5'h04, v); check("R9 clear stat_a", v, 16'h0000);

        // R8 second expiry with no-reboot clear
        sys_ctrl = 8'h00;
        wr(5'h08, 16'h0800);
        wr(5'h00, 16'h0000);
        wr(5'h08, 16'h0000);
        cyc(50);
        check("R8 no reset before second expiry", 16'(rst_pulses), 16'h0000);
        rd(5'h04, v); check("R8 first expiry flag", v, 16'h0001);
        cyc(20);
        check("R8 single reset pulse", 16'(rst_pulses), 16'h0001);
        rd(5'h06, v); check("R8 reset flag", v, 16'h0001);

        // R6 halt freezes count, only bit 11 stored
        wr(5'h08, 16'hFFFF);
        rd(5'h08, v); check("R6 halt readback", v, 16'h0800);
        rd(5'h00, v);
        begin
            logic [15:0] held;
            held = v;
            cyc(50);
            rd(5'h00, v); check("R6 count frozen", v, held);
        end
        wr(5'h08, 16'hF7FF);
        rd(5'h08, v); check("R6 other bits not stored", v, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule